// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits between a data converter channel and its capture interface. It forwards the live 11-bit sample stream, or it puts a known pattern in its place so that software can check that the capture logic latches every bit correctly. A 3-bit mode input selects the source. The choices are live data, constant zeros, constant ones, an alternating checkerboard, a slow ramp, and a fixed word built from two byte-wide configuration values.

Every mode goes through one output register, so the output always follows its inputs by one clock. The ramp and checkerboard sequences keep their own state. That state is cleared whenever the block is not in the matching mode, so each entry into one of these modes starts the sequence from the beginning.

Top module: `adc_tpg`

## Requirements
- R1: While `rst` is high at a rising edge, `data_out` becomes 0 at that edge. The ramp and checkerboard state also clear, so the first word in any mode after reset starts the sequence afresh.
- R2: With `mode_sel` = 3'b000, `data_out` equals the `sample_in` value seen at the previous rising edge.
- R3: With `mode_sel` = 3'b001, `data_out` is 0 one clock later. With `mode_sel` = 3'b010, all 11 bits are 1 (0x7FF) one clock later.
- R4: With `mode_sel` = 3'b011, the first output word after entering the mode is 0x555 (binary 10101010101). Each following word is the bitwise complement of the one before, so the words run 0x555, 0x2AA, 0x555, and so on.
- R5: With `mode_sel` = 3'b100, output word k after entering the mode (k = 0, 1, ...) equals floor(k/8) modulo 2048. Each ramp value is therefore held for 8 clocks and then increases by one LSB.
- R6: The ramp wraps from 2047 back to 0 and keeps counting.
- R7: Leaving ramp mode and entering it again restarts the ramp at 0, with a full 8-clock hold on that first value.
- R8: With `mode_sel` = 3'b101, `data_out` equals {`cust_hi`[7:0], `cust_lo`[7:5]} one clock later. `cust_lo`[4:0] has no effect on the output.
- R9: Codes 3'b110 and 3'b111 behave exactly as 3'b000 and pass `sample_in` through with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 11 | Live converter sample |
| mode_sel | input | 3 | Output source select |
| cust_hi | input | 8 | Upper 8 bits of the custom word |
| cust_lo | input | 8 | Bits [7:5] supply the lower 3 bits of the custom word |
| data_out | output | 11 | Registered output word |

## Verification
The bench builds the block with its default parameters: an 11-bit word, an 8-bit upper custom field, and an 8-clock ramp step. With these values a complete ramp period of 16384 clocks is short enough to run in full, including the wrap from 2047 to 0. The same settings allow exhaustive sweeps of all 2048 live sample codes and of every combination of the custom word's 256 upper values with its 3 lower bits. The sequence modes are also left and re-entered so that the restart behaviour is exercised.

// File: rtl/adc_tpg.sv
module adc_tpg #(
  parameter int DW        = 11,
  parameter int HI_W      = 8,
  parameter int STEP_LOG2 = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   sample_in,
  input  logic [2:0]      mode_sel,
  input  logic [HI_W-1:0] cust_hi,
  input  logic [7:0]      cust_lo,
  output logic [DW-1:0]   data_out
);

  localparam int LO_W = DW - HI_W;
  localparam int ALT_W = 2 * ((DW + 1) / 2);
  localparam logic [ALT_W-1:0] ALT_FULL = {((DW + 1) / 2){2'b01}};
  localparam logic [DW-1:0] PAT_A = ALT_FULL[DW-1:0];
  localparam logic [DW-1:0] PAT_B = ~PAT_A;

  localparam logic [2:0] M_ZERO = 3'b001;
  localparam logic [2:0] M_ONE  = 3'b010;
  localparam logic [2:0] M_ALT  = 3'b011;
  localparam logic [2:0] M_RAMP = 3'b100;
  localparam logic [2:0] M_CUST = 3'b101;

  logic [DW-1:0]        ramp_q;
  logic [STEP_LOG2-1:0] pre_q;
  logic                 ph_q;
  logic [DW-1:0]        nxt;

  wire in_ramp = (mode_sel == M_RAMP);
  wire in_alt  = (mode_sel == M_ALT);
  wire [DW-1:0] cust_word = {cust_hi, cust_lo[7 -: LO_W]};

  always_comb begin
    case (mode_sel)
      M_ZERO:  nxt = '0;
      M_ONE:   nxt = '1;
      M_ALT:   nxt = ph_q ? PAT_B : PAT_A;
      M_RAMP:  nxt = ramp_q;
      M_CUST:  nxt = cust_word;
      default: nxt = sample_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      ramp_q   <= '0;
      pre_q    <= '0;
      ph_q     <= 1'b0;
    end else begin
      data_out <= nxt;
      ph_q     <= in_alt ? ~ph_q : 1'b0;
      if (in_ramp) begin
        pre_q <= pre_q + 1'b1;
        if (&pre_q) ramp_q <= ramp_q + 1'b1;
      end else begin
        pre_q  <= '0;
        ramp_q <= '0;
      end
    end
  end

endmodule

module adc_tpg_chk #(
  parameter int DW   = 11,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   sample_in,
  input logic [2:0]      mode_sel,
  input logic [HI_W-1:0] cust_hi,
  input logic [7:0]      cust_lo,
  input logic [DW-1:0]   data_out
);
  localparam int LO_W = DW - HI_W;

  logic armed  = 1'b0;
  logic armed2 = 1'b0;
  logic was_rst = 1'b0;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    armed   <= !rst;
    armed2  <= armed && !rst;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    was_rst |-> data_out == '0);

  assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_sel) == 3'b000 |-> data_out == $past(sample_in));

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_sel) == 3'b001 |-> data_out == '0);

  assert_ones_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_sel) == 3'b010 |-> data_out == '1);

  assert_alt_flip_R4: assert property (@(posedge clk) disable iff (rst)
    armed2 && $past(mode_sel) == 3'b011 && $past(mode_sel, 2) == 3'b011
    |-> data_out == ~$past(data_out));

  assert_ramp_step_R5: assert property (@(posedge clk) disable iff (rst)
    armed2 && $past(mode_sel) == 3'b100 && $past(mode_sel, 2) == 3'b100
    |-> (data_out == $past(data_out)) || (data_out == DW'($past(data_out) + 1'b1)));

  assert_ramp_entry_R7: assert property (@(posedge clk) disable iff (rst)
    armed2 && $past(mode_sel) == 3'b100 && $past(mode_sel, 2) != 3'b100
    |-> data_out == '0);

  assert_custom_R8: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_sel) == 3'b101
    |-> data_out == {$past(cust_hi), $past(cust_lo[7 -: LO_W])});

  assert_unused_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_sel[2:1]) == 2'b11 |-> data_out == $past(sample_in));

endmodule

bind adc_tpg adc_tpg_chk #(.DW(DW), .HI_W(HI_W)) chk (
  .clk(clk), .rst(rst), .sample_in(sample_in), .mode_sel(mode_sel),
  .cust_hi(cust_hi), .cust_lo(cust_lo), .data_out(data_out)
);

// File: tb/adc_tpg_test.sv
module adc_tpg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] sample_in = '0;
  logic [2:0]  mode_sel = '0;
  logic [7:0]  cust_hi = '0;
  logic [7:0]  cust_lo = '0;
  logic [10:0] data_out;

  int vectors = 0;
  int errors  = 0;
  int rcnt = 0;
  int tcnt = 0;

  always #5 clk = ~clk;

  adc_tpg uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .mode_sel(mode_sel),
    .cust_hi(cust_hi), .cust_lo(cust_lo), .data_out(data_out)
  );

  task automatic check(input string rid, input logic [10:0] exp);
    vectors++;
    if (data_out !== exp) begin
      errors++;
      $display("FAIL %s: data_out=%h expected=%h mode=%b", rid, data_out, exp, mode_sel);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [10:0] d,
                       input logic [7:0] h, input logic [7:0] l, input string rid);
    logic [10:0] exp;
    mode_sel = m; sample_in = d; cust_hi = h; cust_lo = l;
    case (m)
      3'b001: exp = 11'h000;
      3'b010: exp = 11'h7FF;
      3'b011: exp = (tcnt % 2 == 0) ? 11'h555 : 11'h2AA;
      3'b100: exp = 11'((rcnt / 8) % 2048);
      3'b101: exp = {h, l[7:5]};
      default: exp = d;
    endcase
    tcnt = (m == 3'b011) ? tcnt + 1 : 0;
    rcnt = (m == 3'b100) ? rcnt + 1 : 0;
    @(posedge clk); #1;
    check(rid, exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: data_out=%h expected=run completion", data_out);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_sel = 3'b010; sample_in = 11'h3C3;
    @(posedge clk); #1; check("R1", 11'h000);
    mode_sel = 3'b100;
    @(posedge clk); #1; check("R1", 11'h000);
    rst = 1'b0; rcnt = 0; tcnt = 0;
    for (int i = 0; i < 20; i++) apply(3'b100, 11'h0, 8'h0, 8'h0, "R1");

    for (int i = 0; i < 2048; i++) apply(3'b000, 11'(i), 8'hA5, 8'hFF, "R2");

    for (int i = 0; i < 300; i++) apply(3'b001, 11'((i * 613) % 2048), 8'hFF, 8'hFF, "R3");
    for (int i = 0; i < 300; i++) apply(3'b010, 11'((i * 389) % 2048), 8'h00, 8'h00, "R3");

    for (int i = 0; i < 41; i++) apply(3'b011, 11'(i), 8'h0, 8'h0, "R4");
    for (int i = 0; i < 3; i++) apply(3'b000, 11'h123, 8'h0, 8'h0, "R2");
    for (int i = 0; i < 9; i++) apply(3'b011, 11'h7FF, 8'h0, 8'h0, "R4");

    for (int i = 0; i < 16384 + 40; i++)
      apply(3'b100, 11'((i * 7) % 2048), 8'h0, 8'h0, (i >= 16376) ? "R6" : "R5");
    for (int i = 0; i < 3; i++) apply(3'b001, 11'h0, 8'h0, 8'h0, "R3");
    for (int i = 0; i < 100; i++) apply(3'b100, 11'h0, 8'h0, 8'h0, "R7");
    for (int i = 0; i < 5; i++) apply(3'b011, 11'h0, 8'h0, 8'h0, "R4");
    for (int i = 0; i < 30; i++) apply(3'b100, 11'h0, 8'h0, 8'h0, "R7");

    for (int h = 0; h < 256; h++)
      for (int l = 0; l < 8; l++)
        apply(3'b101, 11'((h * 11) % 2048), 8'(h), 8'((l << 5) | ((h + l * 3) % 32)), "R8");

    for (int i = 0; i < 512; i++) apply(3'b110, 11'((i * 2039) % 2048), 8'h5A, 8'hE0, "R9");
    for (int i = 0; i < 512; i++) apply(3'b111, 11'((i * 1021 + 5) % 2048), 8'hC3, 8'h20, "R9");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule